// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding Selector

This block is the forwarding decision logic of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It sits in the decode stage. It compares the two source register indices of the decoding instruction with the destination indices of the two older instructions, which are now in the execute and memory stages. From that comparison it produces the select codes for the two four-input ALU operand multiplexers and for the two store-data multiplexers. The pipeline registers then carry these selects down with the instruction. Because the selects are ready one stage early, the execute stage only has to apply a registered select and does not have to compare register indices.

The logic is purely combinational, with no clock, no reset and no storage. An older instruction in write-back is not compared. The register file commits early in the cycle, so decode already reads the new value. The block does not check whether a producer is a load. Stalling for a load that is used by the next instruction is the job of a separate hazard unit. The store-data selects are kept apart from the ALU selects, so a store placed directly after a load gets the loaded value from the write-back stage without a stall.

Top module: `fwd_ctrl_unit`

## Requirements
- R1: When the execute-stage instruction writes a nonzero register equal to the decode Rs and the shift amount is not in use, `alu_sel_a` is 2'b01 (result one stage ahead).
- R2: When only the memory-stage instruction writes a nonzero register equal to the decode Rs and the shift amount is not in use, `alu_sel_a` is 2'b10 (result two stages ahead).
- R3: When both older instructions write the register being read, the younger (execute-stage) one wins: the select is 2'b01.
- R4: A producer whose destination is register 0, or whose write enable is low, never causes a forward on any output.
- R5: When `use_shamt` is high, `alu_sel_a` is 2'b11 (instruction field), whatever the register matches are.
- R6: When `use_imm` is high, `alu_sel_b` is 2'b11 (instruction field), whatever the register matches are.
- R7: With no qualifying match and no field operand in use, both ALU selects are 2'b00 (register-file data).
- R8: Operand B follows the same match and priority rules as operand A (R1 to R3), applied to the decode Rt.
- R9: `st_sel_mem` is high exactly when the execute-stage instruction writes a nonzero register equal to the decode Rt. This holds regardless of `use_imm` and `use_shamt`, so a store right behind a load receives the load data at the memory stage.
- R10: `st_sel_ex` is high exactly when the memory-stage instruction writes a nonzero register equal to the decode Rt. This holds regardless of `use_imm` and `use_shamt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_rs | input | 5 | Rs index of the instruction in decode |
| dec_rt | input | 5 | Rt index of the instruction in decode |
| ex_dst | input | 5 | Destination index of the execute-stage instruction |
| mem_dst | input | 5 | Destination index of the memory-stage instruction |
| ex_wr_en | input | 1 | Execute-stage instruction writes the register file |
| mem_wr_en | input | 1 | Memory-stage instruction writes the register file |
| use_shamt | input | 1 | Operand A is the shift-amount field |
| use_imm | input | 1 | Operand B is the immediate field |
| alu_sel_a | output | 2 | Operand A select: 00 register file, 01 one ahead, 10 two ahead, 11 field |
| alu_sel_b | output | 2 | Operand B select, same encoding |
| st_sel_ex | output | 1 | Store-data mux in execute takes the write-back result |
| st_sel_mem | output | 1 | Store-data mux in memory takes the write-back result |

## Verification
The ALU operand-B decision and the store-data decision both depend on a match on the same Rt, so they can fire in the same evaluation. A store (with `use_imm` high) that sits behind a producer of its Rt must show operand B on the field code while a store-data select is also asserted. An ALU instruction in the same situation must show a forwarding code on operand B and the same store bit. The bench draws the register indices from a small pool so that these overlaps happen often. It also builds directed cases where both older stages write Rt. In each case every output is compared with a value the bench computes from the requirements.

// File: rtl/fwd_pkg.sv
// Package: shared encodings for the decode-stage forwarding selector.
// Assumes a four-input ALU operand mux whose input order matches opsel_e.
package fwd_pkg;
    typedef enum logic [1:0] {
        OPSEL_RF    = 2'b00,  // register-file read data
        OPSEL_NEAR  = 2'b01,  // result of the instruction one stage ahead
        OPSEL_FAR   = 2'b10,  // result of the instruction two stages ahead
        OPSEL_FIELD = 2'b11   // immediate or shift-amount field
    } opsel_e;
endpackage

// File: rtl/fwd_src_match.sv
// Module: fwd_src_match
// Flags that one source index is produced by one older stage.
// Assumes register index 0 is hard-wired zero and is never a real producer.
module fwd_src_match #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] src_idx,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic             dst_we,
    output logic             hit
);
    // Qualified equality: enabled write, nonzero destination, same index.
    always_comb begin
        hit = dst_we && (dst_idx != '0) && (dst_idx == src_idx);
    end
endmodule

// File: rtl/fwd_opsel.sv
// Module: fwd_opsel
// Turns the match flags of one operand into a mux select code.
// Assumes the field operand overrides any forward and the younger producer wins.
module fwd_opsel
    import fwd_pkg::*;
(
    input  logic   use_field,
    input  logic   hit_near,
    input  logic   hit_far,
    output opsel_e sel
);
    // Priority select: field, then nearest producer, then farther, then RF.
    always_comb begin
        if (use_field)     sel = OPSEL_FIELD;
        else if (hit_near) sel = OPSEL_NEAR;
        else if (hit_far)  sel = OPSEL_FAR;
        else               sel = OPSEL_RF;
    end
endmodule

// File: rtl/fwd_ctrl_unit.sv
// Module: fwd_ctrl_unit (top)
// Decode-stage forwarding selector: computes ALU operand and store-data
// mux selects for the instruction in decode. Purely combinational.
// Assumes the register file writes early enough that write-back needs no compare,
// and that load-use stalls are handled elsewhere.
module fwd_ctrl_unit
    import fwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] dec_rs,
    input  logic [IDX_W-1:0] dec_rt,
    input  logic [IDX_W-1:0] ex_dst,
    input  logic [IDX_W-1:0] mem_dst,
    input  logic             ex_wr_en,
    input  logic             mem_wr_en,
    input  logic             use_shamt,
    input  logic             use_imm,
    output logic [1:0]       alu_sel_a,
    output logic [1:0]       alu_sel_b,
    output logic             st_sel_ex,
    output logic             st_sel_mem
);
    localparam int N_SRC = 2;  // operand 0 = Rs, operand 1 = Rt
    localparam int N_STG = 2;  // stage 0 = execute (near), stage 1 = memory (far)

    logic [N_SRC-1:0][IDX_W-1:0] src_idx;
    logic [N_STG-1:0][IDX_W-1:0] stg_dst;
    logic [N_STG-1:0]            stg_we;
    logic [N_SRC-1:0]            use_field;
    logic [N_SRC-1:0][N_STG-1:0] hit;
    opsel_e                      sel [N_SRC];

    // Gather per-operand and per-stage inputs into indexed vectors.
    always_comb begin
        src_idx[0]   = dec_rs;
        src_idx[1]   = dec_rt;
        stg_dst[0]   = ex_dst;
        stg_dst[1]   = mem_dst;
        stg_we[0]    = ex_wr_en;
        stg_we[1]    = mem_wr_en;
        use_field[0] = use_shamt;
        use_field[1] = use_imm;
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        for (genvar p = 0; p < N_STG; p++) begin : g_stg
            fwd_src_match #(.IDX_W(IDX_W)) u_match (
                .src_idx (src_idx[s]),
                .dst_idx (stg_dst[p]),
                .dst_we  (stg_we[p]),
                .hit     (hit[s][p])
            );
        end
        fwd_opsel u_sel (
            .use_field (use_field[s]),
            .hit_near  (hit[s][0]),
            .hit_far   (hit[s][1]),
            .sel       (sel[s])
        );
    end

    // Drive the outputs; store data always reads Rt, so its selects ignore field use.
    always_comb begin
        alu_sel_a  = sel[0];
        alu_sel_b  = sel[1];
        st_sel_mem = hit[1][0];
        st_sel_ex  = hit[1][1];
    end
endmodule

// File: rtl/fwd_ctrl_unit_chk.sv
// Module: fwd_ctrl_unit_chk
// Port-level checker for the forwarding selector, attached by bind.
// The block has no clock, so the checks are immediate ones on settled values.
module fwd_ctrl_unit_chk #(
    parameter int IDX_W = 5
) (
    input logic [IDX_W-1:0] dec_rs,
    input logic [IDX_W-1:0] dec_rt,
    input logic [IDX_W-1:0] ex_dst,
    input logic [IDX_W-1:0] mem_dst,
    input logic             ex_wr_en,
    input logic             mem_wr_en,
    input logic             use_shamt,
    input logic             use_imm,
    input logic [1:0]       alu_sel_a,
    input logic [1:0]       alu_sel_b,
    input logic             st_sel_ex,
    input logic             st_sel_mem
);
    logic ex_ok, mem_ok;

    // Producer qualification shared by the checks below.
    always_comb begin
        ex_ok  = ex_wr_en && (ex_dst != '0);
        mem_ok = mem_wr_en && (mem_dst != '0);
    end

    // Relate outputs to inputs once the combinational values have settled.
    always_comb begin
        if (!use_shamt && ex_ok && ex_dst == dec_rs)
            a_r1_near_fwd_a: assert (alu_sel_a == 2'b01) else $error("R1 sel_a");
        if (!use_shamt && mem_ok && mem_dst == dec_rs && !(ex_ok && ex_dst == dec_rs))
            a_r2_far_fwd_a: assert (alu_sel_a == 2'b10) else $error("R2 sel_a");
        if (!use_imm && ex_ok && mem_ok && ex_dst == dec_rt && mem_dst == dec_rt)
            a_r3_near_wins_b: assert (alu_sel_b == 2'b01) else $error("R3 sel_b");
        if (!ex_ok && !mem_ok)
            a_r4_no_producer: assert (!st_sel_ex && !st_sel_mem
                                      && alu_sel_a != 2'b01 && alu_sel_a != 2'b10
                                      && alu_sel_b != 2'b01 && alu_sel_b != 2'b10)
                else $error("R4 forward without producer");
        if (use_shamt)
            a_r5_shamt_field: assert (alu_sel_a == 2'b11) else $error("R5 sel_a");
        if (use_imm)
            a_r6_imm_field: assert (alu_sel_b == 2'b11) else $error("R6 sel_b");
        if (!use_shamt && !(ex_ok && ex_dst == dec_rs) && !(mem_ok && mem_dst == dec_rs))
            a_r7_rf_default: assert (alu_sel_a == 2'b00) else $error("R7 sel_a");
        a_r9_store_mem: assert (st_sel_mem == (ex_ok && ex_dst == dec_rt))
            else $error("R9 st_sel_mem");
        a_r10_store_ex: assert (st_sel_ex == (mem_ok && mem_dst == dec_rt))
            else $error("R10 st_sel_ex");
    end
endmodule

bind fwd_ctrl_unit fwd_ctrl_unit_chk #(.IDX_W(IDX_W)) u_chk (
    .dec_rs     (dec_rs),
    .dec_rt     (dec_rt),
    .ex_dst     (ex_dst),
    .mem_dst    (mem_dst),
    .ex_wr_en   (ex_wr_en),
    .mem_wr_en  (mem_wr_en),
    .use_shamt  (use_shamt),
    .use_imm    (use_imm),
    .alu_sel_a  (alu_sel_a),
    .alu_sel_b  (alu_sel_b),
    .st_sel_ex  (st_sel_ex),
    .st_sel_mem (st_sel_mem)
);

// File: tb/fwd_ctrl_unit_test.sv
// Bench for fwd_ctrl_unit: directed corners plus seeded random vectors,
// each compared with values computed from the requirements.
module fwd_ctrl_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 5;
    localparam int N_RANDOM   = 2000;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic [IDX_W-1:0] dec_rs, dec_rt, ex_dst, mem_dst;
    logic ex_wr_en, mem_wr_en, use_shamt, use_imm;
    logic [1:0] alu_sel_a, alu_sel_b;
    logic st_sel_ex, st_sel_mem;
    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fwd_ctrl_unit #(.IDX_W(IDX_W)) uut (
        .dec_rs(dec_rs), .dec_rt(dec_rt), .ex_dst(ex_dst), .mem_dst(mem_dst),
        .ex_wr_en(ex_wr_en), .mem_wr_en(mem_wr_en),
        .use_shamt(use_shamt), .use_imm(use_imm),
        .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b),
        .st_sel_ex(st_sel_ex), .st_sel_mem(st_sel_mem)
    );

    // Qualified producer match (R4: enable high and nonzero destination).
    function automatic bit prod(input logic [IDX_W-1:0] src, input logic [IDX_W-1:0] dst,
                                input logic we);
        return we && dst != 0 && dst == src;
    endfunction

    // Operand select per R1, R2, R3, R5, R6, R7, R8.
    function automatic logic [1:0] want_sel(input logic fld, input logic [IDX_W-1:0] src);
        if (fld) return 2'b11;
        if (prod(src, ex_dst, ex_wr_en)) return 2'b01;
        if (prod(src, mem_dst, mem_wr_en)) return 2'b10;
        return 2'b00;
    endfunction

    task automatic apply(input logic [IDX_W-1:0] rs, input logic [IDX_W-1:0] rt,
                         input logic [IDX_W-1:0] ed, input logic [IDX_W-1:0] md,
                         input logic ew, input logic mw, input logic sh, input logic im,
                         input string tag);
        logic [1:0] ea, eb;
        logic es_ex, es_mem;
        @(posedge clk);
        dec_rs = rs; dec_rt = rt; ex_dst = ed; mem_dst = md;
        ex_wr_en = ew; mem_wr_en = mw; use_shamt = sh; use_imm = im;
        @(negedge clk);
        ea     = want_sel(sh, rs);
        eb     = want_sel(im, rt);
        es_mem = prod(rt, ed, ew);   // R9
        es_ex  = prod(rt, md, mw);   // R10
        n_vec++;
        if (alu_sel_a !== ea) begin
            n_bad++;
            $display("FAIL %s alu_sel_a got %b exp %b", tag, alu_sel_a, ea);
        end
        if (alu_sel_b !== eb) begin
            n_bad++;
            $display("FAIL %s alu_sel_b got %b exp %b", tag, alu_sel_b, eb);
        end
        if (st_sel_mem !== es_mem) begin
            n_bad++;
            $display("FAIL %s(R9) st_sel_mem got %b exp %b", tag, st_sel_mem, es_mem);
        end
        if (st_sel_ex !== es_ex) begin
            n_bad++;
            $display("FAIL %s(R10) st_sel_ex got %b exp %b", tag, st_sel_ex, es_ex);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_0f0d);
        dec_rs = '0; dec_rt = '0; ex_dst = '0; mem_dst = '0;
        ex_wr_en = 1'b0; mem_wr_en = 1'b0; use_shamt = 1'b0; use_imm = 1'b0;
        // Idle inputs: register-file selects and no store forwarding (R7).
        apply(0, 0, 0, 0, 0, 0, 0, 0, "R7_idle");
        apply(3, 4, 3, 9, 1, 1, 0, 0, "R1_near_a");
        apply(3, 4, 9, 3, 1, 1, 0, 0, "R2_far_a");
        apply(6, 6, 6, 6, 1, 1, 0, 0, "R3_both_rs_rt");
        apply(0, 0, 0, 0, 1, 1, 0, 0, "R4_reg_zero");
        apply(5, 5, 5, 5, 0, 0, 0, 0, "R4_no_write");
        apply(5, 7, 5, 7, 0, 1, 0, 0, "R4_ex_disabled");
        apply(8, 2, 8, 8, 1, 1, 1, 0, "R5_shamt");
        apply(2, 8, 8, 8, 1, 1, 0, 1, "R6_imm");
        apply(1, 9, 3, 4, 1, 1, 0, 0, "R8_no_match");
        apply(1, 9, 9, 4, 1, 1, 0, 0, "R8_near_b");
        apply(1, 9, 4, 9, 1, 1, 0, 0, "R8_far_b");
        // Store right behind a load of its Rt: B is immediate, store data forwarded.
        apply(2, 12, 12, 0, 1, 0, 0, 1, "R9_store_after_load");
        apply(2, 12, 0, 12, 0, 1, 0, 1, "R10_store_two_back");
        apply(12, 12, 12, 12, 1, 1, 1, 1, "R9_R10_both_fields");
        apply(31, 31, 31, 31, 1, 1, 0, 0, "R3_top_index");
        // Random vectors with indices from a small pool to force overlaps.
        for (int i = 0; i < N_RANDOM; i++) begin
            apply(IDX_W'($urandom_range(0, 3)), IDX_W'($urandom_range(0, 3)),
                  IDX_W'($urandom_range(0, 3)), IDX_W'($urandom_range(0, 3)),
                  1'($urandom), 1'($urandom),
                  1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 2) == 0),
                  "R1_R10_random");
        end
        done = 1'b1;
    end

    // Watchdog and summary.
    initial begin
        for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog run did not complete got timeout exp done");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule